// File: doc/BRIEF.md
# Translation Region Selector

This block decides which of two translation-table configurations serves a 64-bit input address. Each table has a size field. When the field is nonzero, it marks a window of upper address bits that must hold a fixed pattern. For the lower table the pattern is all zeros; for the upper table it is all ones. When the field is zero, that table takes every address the other table does not claim.

Two ignore-top-byte enables are available. Address bit 55 picks which enable applies. When the chosen enable is active, the eight most significant address bits are removed from the membership window, so a tag stored in the top byte does not affect the choice.

Each table can also be disabled. An address that lands in the gap between two sized regions causes a translation fault. An address that resolves to a disabled table also causes a translation fault.

The requester pulses a request strobe together with the address and the configuration. One clock later the block returns a response pulse with the outcome.

Top module: `region_selector`

## Requirements
- R1: `resp_valid` is high in the cycle after each cycle with `req_valid` high, and low after each cycle with `req_valid` low. The result fields are updated in that same cycle.
- R2: The ignore-top-byte enable in force is `tbi_en[0]` when address bit 55 is 0, and `tbi_en[1]` when address bit 55 is 1.
- R3: While the enable in force is set, address bits 63..56 are excluded from the membership window. The window for a table of size S then covers bits 64-S up to 55. If that range is empty, the address is always a member.
- R4: The highest-priority outcome is table 0. It applies when `t0_size` is nonzero and address bits 63 down to 64-`t0_size` (within the window) are all zero.
- R5: The second-priority outcome is table 1. It applies when `t1_size` is nonzero and the bits in its window are all ones.
- R6: Failing R4 and R5, table 0 is chosen if `t0_size` is zero.
- R7: Failing R4 to R6, table 1 is chosen if `t1_size` is zero.
- R8: If no rule applies (the gap), the response has `resp_fault`=1, `resp_hit`=0 and `resp_table`=0.
- R9: If the chosen table is disabled (`t0_off` or `t1_off`), the response has `resp_fault`=1 and `resp_hit`=0, with `resp_table` naming the chosen table. The disable flag of the table not chosen has no effect.
- R10: Reset clears all outputs to 0. Without a request, the result fields hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Address to classify |
| t0_size | input | 6 | Region size field of table 0 |
| t1_size | input | 6 | Region size field of table 1 |
| tbi_en | input | 2 | Ignore-top-byte enables (bit 0 for bit 55 clear, bit 1 for set) |
| t0_off | input | 1 | Table 0 disabled |
| t1_off | input | 1 | Table 1 disabled |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | A usable table was selected |
| resp_table | output | 1 | Index of the chosen table |
| resp_fault | output | 1 | Translation fault |

## Verification
Every result has exactly one register between the request and the outputs. The response pulse and all three result fields are therefore due in the first cycle after the strobe.

The bench drives each request on a falling edge and drops the strobe on the next falling edge. It reads the fields at that falling edge, half a period after the edge that loads them.

One idle cycle follows each request, and the bench changes the inputs during it. It then checks that the pulse has ended and that the fields are unchanged.

// File: rtl/region_sel_pkg.sv
package region_sel_pkg;

    localparam int ADDR_W   = 64;
    localparam int SIZE_W   = 6;
    localparam int IGN_BITS = 8;
    localparam int PICK_BIT = 55;

    typedef enum logic [2:0] {
        RULE_GAP     = 3'd0,
        RULE_T0_IN   = 3'd1,
        RULE_T1_IN   = 3'd2,
        RULE_T0_REST = 3'd3,
        RULE_T1_REST = 3'd4
    } sel_rule_t;

    typedef struct packed {
        logic hit;
        logic table_idx;
        logic fault;
    } sel_result_t;

    function automatic logic rule_is_t1(sel_rule_t r);
        return (r == RULE_T1_IN) || (r == RULE_T1_REST);
    endfunction

endpackage

// File: rtl/region_sel_tbi_pick.sv
module region_sel_tbi_pick #(
    parameter int ADDR_W   = region_sel_pkg::ADDR_W,
    parameter int PICK_BIT = region_sel_pkg::PICK_BIT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        tbi_en,
    output logic              tbi_on
);
    always_comb begin
        tbi_on = addr[PICK_BIT] ? tbi_en[1] : tbi_en[0];
    end
endmodule

// File: rtl/region_sel_match.sv
module region_sel_match #(
    parameter int ADDR_W     = region_sel_pkg::ADDR_W,
    parameter int SIZE_W     = region_sel_pkg::SIZE_W,
    parameter int IGN_BITS   = region_sel_pkg::IGN_BITS,
    parameter bit MATCH_ONES = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              tbi_on,
    output logic              sized,
    output logic              member
);
    logic [ADDR_W-1:0] window;
    logic [ADDR_W-1:0] picked;
    int                lo_bit;
    int                hi_excl;

    always_comb begin
        lo_bit  = ADDR_W - int'(size);
        hi_excl = ADDR_W - (tbi_on ? IGN_BITS : 0);
        for (int i = 0; i < ADDR_W; i++) begin
            window[i] = (i >= lo_bit) && (i < hi_excl);
        end
        picked = addr & window;
        sized  = (size != '0);
    end

    generate
        if (MATCH_ONES) begin : g_ones
            assign member = (picked == window);
        end else begin : g_zeros
            assign member = (picked == '0);
        end
    endgenerate
endmodule

// File: rtl/region_sel_priority.sv
module region_sel_priority
    import region_sel_pkg::*;
(
    input  logic        t0_sized,
    input  logic        t0_member,
    input  logic        t1_sized,
    input  logic        t1_member,
    input  logic        t0_off,
    input  logic        t1_off,
    output sel_result_t result
);
    sel_rule_t rule;
    logic      pick_t1;
    logic      off_hit;

    always_comb begin
        if (t0_sized && t0_member) begin
            rule = RULE_T0_IN;
        end else if (t1_sized && t1_member) begin
            rule = RULE_T1_IN;
        end else if (!t0_sized) begin
            rule = RULE_T0_REST;
        end else if (!t1_sized) begin
            rule = RULE_T1_REST;
        end else begin
            rule = RULE_GAP;
        end

        pick_t1          = rule_is_t1(rule);
        off_hit          = pick_t1 ? t1_off : t0_off;
        result.table_idx = pick_t1;
        result.fault     = (rule == RULE_GAP) || off_hit;
        result.hit       = !result.fault;
    end
endmodule

// File: rtl/region_selector.sv
module region_selector
    import region_sel_pkg::*;
#(
    parameter int ADDR_W   = region_sel_pkg::ADDR_W,
    parameter int SIZE_W   = region_sel_pkg::SIZE_W,
    parameter int IGN_BITS = region_sel_pkg::IGN_BITS,
    parameter int PICK_BIT = region_sel_pkg::PICK_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] t0_size,
    input  logic [SIZE_W-1:0] t1_size,
    input  logic [1:0]        tbi_en,
    input  logic              t0_off,
    input  logic              t1_off,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_table,
    output logic              resp_fault
);
    localparam int NUM_TABLES = 2;

    logic                  tbi_on;
    logic [SIZE_W-1:0]     sizes  [NUM_TABLES];
    logic [NUM_TABLES-1:0] sized;
    logic [NUM_TABLES-1:0] member;
    sel_result_t           result_d;
    sel_result_t           result_q;
    logic                  valid_q;

    assign sizes[0] = t0_size;
    assign sizes[1] = t1_size;

    region_sel_tbi_pick #(
        .ADDR_W  (ADDR_W),
        .PICK_BIT(PICK_BIT)
    ) u_tbi (
        .addr  (req_addr),
        .tbi_en(tbi_en),
        .tbi_on(tbi_on)
    );

    generate
        for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
            region_sel_match #(
                .ADDR_W    (ADDR_W),
                .SIZE_W    (SIZE_W),
                .IGN_BITS  (IGN_BITS),
                .MATCH_ONES(t == 1)
            ) u_match (
                .addr  (req_addr),
                .size  (sizes[t]),
                .tbi_on(tbi_on),
                .sized (sized[t]),
                .member(member[t])
            );
        end
    endgenerate

    region_sel_priority u_prio (
        .t0_sized (sized[0]),
        .t0_member(member[0]),
        .t1_sized (sized[1]),
        .t1_member(member[1]),
        .t0_off   (t0_off),
        .t1_off   (t1_off),
        .result   (result_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                result_q <= result_d;
            end
        end
    end

    assign resp_valid = valid_q;
    assign resp_hit   = result_q.hit;
    assign resp_table = result_q.table_idx;
    assign resp_fault = result_q.fault;
endmodule

// File: rtl/region_selector_checker.sv
module region_selector_checker #(
    parameter int SIZE_W = region_sel_pkg::SIZE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [SIZE_W-1:0] t0_size,
    input logic [SIZE_W-1:0] t1_size,
    input logic              t0_off,
    input logic              t1_off,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_table,
    input logic              resp_fault
);
    assert_pulse_on_req_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    assert_no_pulse_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(resp_hit) && $stable(resp_table) && $stable(resp_fault)));

    assert_both_rest_t0_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && t0_size == '0 && t1_size == '0 && !t0_off)
        |=> (resp_hit && !resp_table && !resp_fault));

    assert_no_gap_one_rest_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (t0_size == '0 || t1_size == '0) && !t0_off && !t1_off)
        |=> (resp_hit && !resp_fault));

    assert_both_off_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && t0_off && t1_off) |=> (resp_fault && !resp_hit));
endmodule

bind region_selector region_selector_checker #(.SIZE_W(SIZE_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .t0_size   (t0_size),
    .t1_size   (t1_size),
    .t0_off    (t0_off),
    .t1_off    (t1_off),
    .resp_valid(resp_valid),
    .resp_hit  (resp_hit),
    .resp_table(resp_table),
    .resp_fault(resp_fault)
);

// File: tb/region_selector_test.sv
module region_selector_test;

    typedef struct packed {
        logic [63:0] addr;
        logic [5:0]  s0;
        logic [5:0]  s1;
        logic [1:0]  tbi;
        logic        off0;
        logic        off1;
        logic        hit;
        logic        tbl;
        logic        flt;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_1234_5678_9ABC, 6'd16, 6'd16, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
        '{64'hFFFF_8000_0000_0000, 6'd16, 6'd16, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5
        '{64'h00FF_0000_0000_0000, 6'd16, 6'd16, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
        '{64'hAB00_1000_0000_0000, 6'd16, 6'd16, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R3
        '{64'h12FF_F000_0000_0000, 6'd16, 6'd16, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 R3
        '{64'h12FF_F000_0000_0000, 6'd16, 6'd16, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2
        '{64'h1234_0000_0000_0000, 6'd0,  6'd16, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
        '{64'hFFFF_0000_0000_0000, 6'd0,  6'd16, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 over R6
        '{64'h1234_0000_0000_0000, 6'd16, 6'd0,  2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R7
        '{64'h0000_0000_0000_0000, 6'd16, 6'd0,  2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 over R7
        '{64'h5555_0000_0000_0000, 6'd0,  6'd0,  2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
        '{64'h0000_0000_0000_0000, 6'd16, 6'd16, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R9
        '{64'hFFFF_0000_0000_0000, 6'd16, 6'd16, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R9
        '{64'h1234_0000_0000_0000, 6'd0,  6'd16, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9
        '{64'hF000_0000_0000_0000, 6'd4,  6'd4,  2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
        '{64'h0000_0040_0000_0000, 6'd25, 6'd25, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
        '{64'h0000_0080_0000_0000, 6'd25, 6'd25, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
        '{64'hFF00_0000_0000_0000, 6'd16, 6'd16, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
        '{64'h00FF_8000_0000_0000, 6'd16, 6'd16, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [5:0]  t0_size = '0;
    logic [5:0]  t1_size = '0;
    logic [1:0]  tbi_en = '0;
    logic        t0_off = 1'b0;
    logic        t1_off = 1'b0;
    logic        resp_valid;
    logic        resp_hit;
    logic        resp_table;
    logic        resp_fault;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    region_selector uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .t0_size   (t0_size),
        .t1_size   (t1_size),
        .tbi_en    (tbi_en),
        .t0_off    (t0_off),
        .t1_off    (t1_off),
        .resp_valid(resp_valid),
        .resp_hit  (resp_hit),
        .resp_table(resp_table),
        .resp_fault(resp_fault)
    );

    task automatic check_out(input string tag, input logic v, input logic h,
                             input logic t, input logic f);
        checks++;
        if ({resp_valid, resp_hit, resp_table, resp_fault} !== {v, h, t, f}) begin
            failures++;
            $display("FAIL %s: actual v/h/t/f=%b%b%b%b expected %b%b%b%b",
                     tag, resp_valid, resp_hit, resp_table, resp_fault, v, h, t, f);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_addr  = v.addr;
        t0_size   = v.s0;
        t1_size   = v.s1;
        tbi_en    = v.tbi;
        t0_off    = v.off0;
        t1_off    = v.off1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out("R10 reset state", 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            check_out($sformatf("R1-vector %0d result", i), 1'b1,
                      VECS[i].hit, VECS[i].tbl, VECS[i].flt);
            // idle cycle with disturbed inputs: R1 pulse ends, R10 fields hold
            req_addr = ~VECS[i].addr;
            t0_off   = ~VECS[i].off0;
            t1_off   = ~VECS[i].off1;
            t0_size  = 6'd0;
            @(negedge clk);
            check_out($sformatf("R10 hold after vector %0d", i), 1'b0,
                      VECS[i].hit, VECS[i].tbl, VECS[i].flt);
        end

        // back-to-back requests: R1 pulse per request, R5 then R8
        @(negedge clk);
        req_addr = 64'hFFFF_0000_0000_0000; t0_size = 6'd16; t1_size = 6'd16;
        tbi_en = 2'b00; t0_off = 1'b0; t1_off = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        check_out("R1 back-to-back first (R5)", 1'b1, 1'b1, 1'b1, 1'b0);
        req_addr = 64'h0100_0000_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check_out("R1 back-to-back second (R8)", 1'b1, 1'b0, 1'b0, 1'b1);

        // reset mid-run clears a held result (R10)
        apply(VECS[1]);
        rst = 1'b1;
        @(negedge clk);
        check_out("R10 reset clears", 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_out("R10 idle after reset", 1'b0, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule